// File: doc/BRIEF.md
# Address-Change Read Sequencer

This block is the timing heart of an asynchronous-style memory read path, rebuilt as a synchronous controller. It has no read strobe. It compares every bit of the address bus against the copy it captured on the previous clock edge. When any bit differs, it starts a detection pulse of fixed width. That pulse is the timing reference for one complete access.

While the pulse runs, the bit lines are equalised and precharged. The controller then lets them float for one cycle. Next it raises the word line, waits a set number of cycles so that a usable differential signal can develop, and fires the sense amplifier for a short burst. The word line and sense enable drop together. One cycle later a data-valid strobe marks the end of the access, and the controller goes back to idle with precharge held on.

A new address change at any point abandons the current access and starts again from equalisation. All phase lengths are parameters counted in clock cycles.

Top module: `atdReadSeq`

## Requirements
- R1: A change on any single address bit, sampled at a clock edge, makes `eqOut` high in the cycle that follows that edge.
- R2: The detection pulse lasts exactly PULSE_W cycles. During the pulse both `eqOut` and `prechargeOut` are high, and `wlEn`, `senseEn` and `dataValid` are low.
- R3: Right after the pulse there is exactly one cycle in which `prechargeOut`, `eqOut` and `wlEn` are all low.
- R4: `wlEn` is then high for SE_DELAY cycles before `senseEn` rises, and `senseEn` never rises unless `wlEn` was high in the cycle before.
- R5: `senseEn` is a pulse exactly SE_CYC cycles long. `wlEn` stays high throughout it.
- R6: `wlEn` and `senseEn` fall in the same cycle.
- R7: `dataValid` is high for exactly one cycle, the cycle right after `senseEn` falls. In that cycle `prechargeOut` is high again.
- R8: An address change during any phase of an access, including the detection pulse itself, restarts the sequence from the first cycle of the detection pulse.
- R9: `eqOut` and `wlEn` are never high together, and `prechargeOut` and `wlEn` are never high together.
- R10: During and after reset, with the address stable, the outputs are idle: `prechargeOut` is high and all other outputs are low. Address activity during reset starts no access once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| addr | input | ADDR_W | Address bus that is watched for changes |
| eqOut | output | 1 | Bit-line equalise; equal to the detection pulse |
| prechargeOut | output | 1 | Bit-line precharge |
| wlEn | output | 1 | Word-line enable |
| senseEn | output | 1 | Sense-amplifier enable pulse |
| dataValid | output | 1 | One-cycle strobe at the end of the access |

## Verification
The bench toggles each address bit alone. A detector that compares only some of the bits would miss one, leave `eqOut` low and run no access. It also moves the address during equalisation, during the float cycle, while the word line is high and while sensing is under way. A sequencer that ignored a late change would finish the old access, raise `dataValid` for stale data, or leave the word line high while equalising. Random hold times between address changes cover many abort points. Other runs hold the address long enough to reach idle, which exposes phase counters that are off by one and a sense pulse that outlasts the word line. The bench also wiggles the address during reset, which shows whether a stray access starts when reset is released.

// File: rtl/atdSeqPkg.sv
package atdSeqPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWl;   // start the word-line wait timer
    logic loadSe;   // start the sense pulse timer
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic atdHit;     // some address bit differs from its captured copy
    logic atdLast;    // final cycle of the detection pulse
    logic timerLast;  // final cycle of the running phase timer
  } seqStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EQUAL,
    ST_FLOAT,
    ST_WORD,
    ST_SENSE,
    ST_DONE
  } seqState_t;

endpackage

// File: rtl/atdSeqDatapath.sv
module atdSeqDatapath
  import atdSeqPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PULSE_W  = 2,
  parameter int SE_DELAY = 3,
  parameter int SE_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  seqCmd_t           cmd,
  output seqStat_t          stat
);

  localparam int PCW  = $clog2(PULSE_W + 1);
  localparam int TMAX = (SE_DELAY > SE_CYC) ? SE_DELAY : SE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] bitFlip;
  logic [PCW-1:0]    pulseCnt;
  logic [TW-1:0]     phaseCnt;
  logic              hit;

  // captured copy follows the bus even in reset, so no stray access on release
  always_ff @(posedge clk) begin
    addrQ <= addr;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bitCmp
    assign bitFlip[i] = addr[i] ^ addrQ[i];
  end

  assign hit = |bitFlip;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pulseCnt <= '0;
    end else if (hit) begin
      pulseCnt <= PCW'(PULSE_W);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phaseCnt <= '0;
    end else if (cmd.loadWl) begin
      phaseCnt <= TW'(SE_DELAY);
    end else if (cmd.loadSe) begin
      phaseCnt <= TW'(SE_CYC);
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  assign stat.atdHit    = hit;
  assign stat.atdLast   = (pulseCnt == PCW'(1));
  assign stat.timerLast = (phaseCnt == TW'(1));

endmodule

// File: rtl/atdSeqControl.sv
module atdSeqControl
  import atdSeqPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  seqStat_t stat,
  output seqCmd_t  cmd,
  output logic     eqOut,
  output logic     prechargeOut,
  output logic     wlEn,
  output logic     senseEn,
  output logic     dataValid
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    if (stat.atdHit) begin
      stateNext = ST_EQUAL;           // any change restarts the access
    end else begin
      unique case (state)
        ST_IDLE:  stateNext = ST_IDLE;
        ST_EQUAL: if (stat.atdLast) stateNext = ST_FLOAT;
        ST_FLOAT: begin
          stateNext  = ST_WORD;
          cmd.loadWl = 1'b1;
        end
        ST_WORD: if (stat.timerLast) begin
          stateNext  = ST_SENSE;
          cmd.loadSe = 1'b1;
        end
        ST_SENSE: if (stat.timerLast) stateNext = ST_DONE;
        ST_DONE:  stateNext = ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign eqOut        = (state == ST_EQUAL);
  assign prechargeOut = (state == ST_EQUAL) || (state == ST_IDLE) || (state == ST_DONE);
  assign wlEn         = (state == ST_WORD) || (state == ST_SENSE);
  assign senseEn      = (state == ST_SENSE);
  assign dataValid    = (state == ST_DONE);

endmodule

// File: rtl/atdReadSeq.sv
module atdReadSeq
  import atdSeqPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PULSE_W  = 2,
  parameter int SE_DELAY = 3,
  parameter int SE_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic              eqOut,
  output logic              prechargeOut,
  output logic              wlEn,
  output logic              senseEn,
  output logic              dataValid
);

  seqCmd_t  cmd;
  seqStat_t stat;

  atdSeqDatapath #(
    .ADDR_W(ADDR_W), .PULSE_W(PULSE_W), .SE_DELAY(SE_DELAY), .SE_CYC(SE_CYC)
  ) u_dp (
    .clk(clk), .rst(rst), .addr(addr), .cmd(cmd), .stat(stat)
  );

  atdSeqControl u_ctl (
    .clk(clk), .rst(rst), .stat(stat), .cmd(cmd),
    .eqOut(eqOut), .prechargeOut(prechargeOut), .wlEn(wlEn),
    .senseEn(senseEn), .dataValid(dataValid)
  );

endmodule

// File: rtl/atdSeqChecker.sv
module atdSeqChecker #(
  parameter int ADDR_W = 8,
  parameter int SE_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              eqOut,
  input logic              prechargeOut,
  input logic              wlEn,
  input logic              senseEn,
  input logic              dataValid
);

  localparam int CW = $clog2(SE_CYC + 2);

  logic [ADDR_W-1:0] lastAddr;
  logic [CW-1:0]     seRun;

  always_ff @(posedge clk) begin
    lastAddr <= addr;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          seRun <= '0;
    else if (senseEn) seRun <= (seRun == CW'(SE_CYC + 1)) ? seRun : seRun + 1'b1;
    else              seRun <= '0;
  end

  AST_ADDR_START:  assert property (@(posedge clk) disable iff (rst) (addr != lastAddr) |=> eqOut); // R1
  AST_EQ_WL_EXCL:  assert property (@(posedge clk) disable iff (rst) !(eqOut && wlEn)); // R9
  AST_PRE_WL_EXCL: assert property (@(posedge clk) disable iff (rst) !(prechargeOut && wlEn)); // R9
  AST_SE_AFTER_WL: assert property (@(posedge clk) disable iff (rst) $rose(senseEn) |-> $past(wlEn)); // R4
  AST_SE_SHORT:    assert property (@(posedge clk) disable iff (rst) senseEn |-> (seRun < CW'(SE_CYC))); // R5
  AST_SE_WITH_WL:  assert property (@(posedge clk) disable iff (rst) senseEn |-> wlEn); // R5
  AST_WL_SE_FALL:  assert property (@(posedge clk) disable iff (rst) $fell(senseEn) |-> !wlEn); // R6
  AST_VALID_END:   assert property (@(posedge clk) disable iff (rst) dataValid |-> ($past(senseEn) && !senseEn && prechargeOut)); // R7

endmodule

bind atdReadSeq atdSeqChecker #(.ADDR_W(ADDR_W), .SE_CYC(SE_CYC)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .eqOut(eqOut), .prechargeOut(prechargeOut),
  .wlEn(wlEn), .senseEn(senseEn), .dataValid(dataValid)
);

// File: tb/atdReadSeq_bench.sv
`timescale 1ns/1ps
module atdReadSeq_bench;

  localparam int ADDR_W   = 8;
  localparam int PULSE_W  = 2;
  localparam int SE_DELAY = 3;
  localparam int SE_CYC   = 2;
  localparam int SEQ_LEN  = PULSE_W + SE_DELAY + SE_CYC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic eqOut, prechargeOut, wlEn, senseEn, dataValid;

  int nChecks = 0;
  int nFail   = 0;
  int since   = 1000;
  bit finished = 1'b0;
  logic [ADDR_W-1:0] cur = '0;

  always #2.5 clk = ~clk;

  atdReadSeq #(
    .ADDR_W(ADDR_W), .PULSE_W(PULSE_W), .SE_DELAY(SE_DELAY), .SE_CYC(SE_CYC)
  ) u_atdReadSeq (
    .clk(clk), .rst(rst), .addr(addr), .eqOut(eqOut), .prechargeOut(prechargeOut),
    .wlEn(wlEn), .senseEn(senseEn), .dataValid(dataValid)
  );

  // expected {precharge, eq, wl, se, valid} n cycles after the capturing edge
  function automatic logic [4:0] expOut(int n);
    if (n < PULSE_W)                          return 5'b11000;
    if (n == PULSE_W)                         return 5'b00000;
    if (n <= PULSE_W + SE_DELAY)              return 5'b00100;
    if (n <= PULSE_W + SE_DELAY + SE_CYC)     return 5'b00110;
    if (n == PULSE_W + SE_DELAY + SE_CYC + 1) return 5'b10001;
    return 5'b10000;
  endfunction

  function automatic string phaseTag(int n);
    if (n < PULSE_W)                          return "R2";
    if (n == PULSE_W)                         return "R3";
    if (n <= PULSE_W + SE_DELAY)              return "R4";
    if (n <= PULSE_W + SE_DELAY + SE_CYC)     return "R5";
    if (n == PULSE_W + SE_DELAY + SE_CYC + 1) return "R6 R7";
    return "R10";
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: outputs {pre,eq,wl,se,valid} got %b expected %b (since=%0d)",
               tag, got, exp, since);
    end
  endtask

  // called at a negedge: drive, let one edge pass, sample at the next negedge
  task automatic step(logic [ADDR_W-1:0] a, string tag);
    bit changed;
    logic [4:0] got;
    changed = (a != cur);
    addr = a;
    cur  = a;
    @(posedge clk);
    if (changed)          since = 0;
    else if (since < 1000) since++;
    @(negedge clk);
    got = {prechargeOut, eqOut, wlEn, senseEn, dataValid};
    check((tag == "") ? phaseTag(since) : tag, got, expOut(since));
    nChecks++;
    if (eqOut && wlEn) begin
      nFail++;
      $display("FAIL R9: eq and wl both high, got 1 expected 0");
    end
  endtask

  function automatic logic [ADDR_W-1:0] oneHot(int b);
    return {{(ADDR_W-1){1'b0}}, 1'b1} << b;
  endfunction

  initial begin
    logic [ADDR_W-1:0] nxt;
    int unsigned seed;
    seed = 32'h5A17;
    void'($urandom(seed));

    // R10: address wiggles during reset, stable at release
    repeat (4) begin
      @(negedge clk);
      addr = ADDR_W'($urandom);
    end
    @(negedge clk);
    addr = 8'h3C;
    @(negedge clk);
    check("R10", {prechargeOut, eqOut, wlEn, senseEn, dataValid}, 5'b10000);
    rst = 1'b0;
    cur = addr;
    since = 1000;
    repeat (4) step(cur, "R10");

    // R1: every single bit, each access run to completion
    for (int b = 0; b < ADDR_W; b++) begin
      step(cur ^ oneHot(b), "R1");
      repeat (SEQ_LEN + 1) step(cur, "");
    end

    // R8: restart from each phase of an access
    for (int p = 0; p < SEQ_LEN - 1; p++) begin
      step(cur ^ oneHot(p % ADDR_W), "");
      repeat (p) step(cur, "");
      step(cur ^ 8'h81, "R8");
      repeat (SEQ_LEN + 1) step(cur, "");
    end

    // random mix of hold times and change kinds
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 1) == 0) nxt = cur ^ oneHot($urandom_range(0, ADDR_W - 1));
      else                           nxt = ADDR_W'($urandom);
      if (nxt == cur) nxt = cur ^ 8'h01;
      step(nxt, "");
      repeat ($urandom_range(0, SEQ_LEN + 3)) step(cur, "");
    end
    repeat (SEQ_LEN + 1) step(cur, "");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule